// File: doc/BRIEF.md
# Pin Event Flag Detector

This block watches a bank of already synchronized digital pin levels and, for each pin, looks for an event chosen by a 4-bit mode code. The event can be a rising edge, a falling edge, either edge, or a held low or high level. A detected event sets a sticky flag for that pin. A flag for a pin in an interrupt mode feeds one combined interrupt line. A flag for a pin in a transfer-request mode drives that pin's own request line.

Flags are cleared in three ways. Software can write ones to a bank-wide clear mask. Software can also clear through a per-pin clear strobe, which stands for the flag bit in the pin's own configuration word. In a transfer-request mode, a completion pulse for that pin also clears its flag. In a level mode the flag cannot be cleared while the level persists, because the level sets it again each cycle. Input synchronization and glitch filtering happen upstream of this block.

Top module: `pid_detector`

## Requirements
- R1: A synchronous reset clears every flag, so `flag_o`, `irq_o` and `dma_req_o` read zero. During reset the previous-sample register of each pin loads the current pin level, so a pin that is already high at reset release produces no rising edge.
- R2: The mode code of pin p sits in `pin_mode_i[4p+3:4p]`. Code 4'b1001 sets the flag on a rising edge, 4'b1010 on a falling edge and 4'b1011 on either edge. An edge compares the current sample with the sample taken one cycle earlier.
- R3: Code 4'b1000 sets the flag in every cycle the pin is low, and code 4'b1100 in every cycle it is high. A clear issued while the active level is present leaves the flag reading 1 after that clock edge.
- R4: Codes 4'b0001, 4'b0010 and 4'b0011 detect rising, falling and either edge. While the pin is in one of these modes, `dma_req_o[p]` equals its flag.
- R5: `dma_done_i[p]` clears the flag only while pin p is in a transfer-request mode. In any other mode it has no effect.
- R6: A 1 in bit p of `clr_bus_i` or of `clr_pin_i` clears flag p. With no clear and no completion pulse, a flag holds its value.
- R7: When a set event and any clear reach the same pin in the same cycle, the flag ends up set.
- R8: Code 4'b0000 and every code not listed in R2 to R4 never set a flag.
- R9: `irq_o` is the OR of the flags of all pins whose mode is an interrupt mode (R2, R3). A flag that remains set after its pin's mode is changed to disabled drives neither `irq_o` nor `dma_req_o`.
- R10: An event on the pin inputs becomes visible on `flag_o` after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_mode_i | input | NPINS*4 | Per-pin mode codes, pin p in bits [4p+3:4p] |
| pin_lvl_i | input | NPINS | Synchronized pin levels |
| clr_bus_i | input | NPINS | Write-one-to-clear mask for the bank status word |
| clr_pin_i | input | NPINS | Per-pin flag clear strobes from the pin configuration words |
| dma_done_i | input | NPINS | Per-pin transfer completion pulses |
| flag_o | output | NPINS | Sticky event flags (bank status word) |
| irq_o | output | 1 | Combined interrupt request |
| dma_req_o | output | NPINS | Per-pin transfer request lines |

## Verification
The hardest situation to reach is a clear that lands in the same cycle as a set event. In a level mode this has to show the flag staying at 1. For an edge in a transfer-request mode, the completion pulse must coincide exactly with the opposite edge. The stimulus table places the pin at a known previous level and then changes the level, the mode and the clear strobes together in one row, so that the edge and the clear fall in the same cycle. The reset-release test of the previous-sample register holds the pins high, in rising-edge mode, through reset and checks that no flag appears in the first cycles after release.

// File: rtl/pid_pkg.sv
package pid_pkg;

    localparam int MODE_W = 4;

    // Decoded per-pin behaviour
    typedef struct packed {
        logic dma;   // transfer-request mode
        logic irq;   // interrupt mode
        logic rise;  // set on rising edge
        logic fall;  // set on falling edge
        logic lo;    // set while low
        logic hi;    // set while high
    } pid_cfg_t;

    typedef enum logic [MODE_W-1:0] {
        M_OFF      = 4'b0000,
        M_DMA_RISE = 4'b0001,
        M_DMA_FALL = 4'b0010,
        M_DMA_BOTH = 4'b0011,
        M_IRQ_LOW  = 4'b1000,
        M_IRQ_RISE = 4'b1001,
        M_IRQ_FALL = 4'b1010,
        M_IRQ_BOTH = 4'b1011,
        M_IRQ_HIGH = 4'b1100
    } pid_mode_e;

    function automatic pid_cfg_t pid_decode(input logic [MODE_W-1:0] code);
        pid_cfg_t c;
        c = '0;
        case (code)
            M_DMA_RISE: begin c.dma = 1'b1; c.rise = 1'b1; end
            M_DMA_FALL: begin c.dma = 1'b1; c.fall = 1'b1; end
            M_DMA_BOTH: begin c.dma = 1'b1; c.rise = 1'b1; c.fall = 1'b1; end
            M_IRQ_LOW:  begin c.irq = 1'b1; c.lo = 1'b1; end
            M_IRQ_RISE: begin c.irq = 1'b1; c.rise = 1'b1; end
            M_IRQ_FALL: begin c.irq = 1'b1; c.fall = 1'b1; end
            M_IRQ_BOTH: begin c.irq = 1'b1; c.rise = 1'b1; c.fall = 1'b1; end
            M_IRQ_HIGH: begin c.irq = 1'b1; c.hi = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pid_edge_sense.sv
module pid_edge_sense
    import pid_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl_i,
    input  pid_cfg_t cfg_i,
    output logic     set_o
);
    logic prev_q;

    // Previous sample follows the pin during reset: no false edge on release
    always_ff @(posedge clk) begin
        prev_q <= lvl_i;
    end

    logic rise_w, fall_w;
    always_comb begin
        rise_w = lvl_i & ~prev_q & ~rst;
        fall_w = ~lvl_i & prev_q & ~rst;
        set_o  = (cfg_i.rise & rise_w) | (cfg_i.fall & fall_w)
               | (cfg_i.lo & ~lvl_i) | (cfg_i.hi & lvl_i);
    end
endmodule

// File: rtl/pid_flag_cell.sv
module pid_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;   // set has priority over clear
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/pid_detector.sv
module pid_detector
    import pid_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPINS*MODE_W-1:0] pin_mode_i,
    input  logic [NPINS-1:0]        pin_lvl_i,
    input  logic [NPINS-1:0]        clr_bus_i,
    input  logic [NPINS-1:0]        clr_pin_i,
    input  logic [NPINS-1:0]        dma_done_i,
    output logic [NPINS-1:0]        flag_o,
    output logic                    irq_o,
    output logic [NPINS-1:0]        dma_req_o
);
    logic [NPINS-1:0] irq_vec;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pid_cfg_t cfg;
        logic     set_ev;
        logic     clr_ev;

        assign cfg    = pid_decode(pin_mode_i[p*MODE_W +: MODE_W]);
        assign clr_ev = clr_bus_i[p] | clr_pin_i[p] | (dma_done_i[p] & cfg.dma);

        pid_edge_sense u_sense (
            .clk   (clk),
            .rst   (rst),
            .lvl_i (pin_lvl_i[p]),
            .cfg_i (cfg),
            .set_o (set_ev)
        );

        pid_flag_cell u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_ev),
            .clr_i  (clr_ev),
            .flag_o (flag_o[p])
        );

        assign irq_vec[p]   = flag_o[p] & cfg.irq;
        assign dma_req_o[p] = flag_o[p] & cfg.dma;
    end

    assign irq_o = |irq_vec;
endmodule

// File: rtl/pid_checker.sv
module pid_checker #(
    parameter int NPINS = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NPINS*4-1:0]   pin_mode_i,
    input logic [NPINS-1:0]     pin_lvl_i,
    input logic [NPINS-1:0]     clr_bus_i,
    input logic [NPINS-1:0]     clr_pin_i,
    input logic [NPINS-1:0]     dma_done_i,
    input logic [NPINS-1:0]     flag_o,
    input logic                 irq_o,
    input logic [NPINS-1:0]     dma_req_o
);
    // R1: reset empties the status word
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> (flag_o == '0));

    // R4: a request line never stands without its flag
    a_r4_req_needs_flag: assert property (@(posedge clk) disable iff (rst)
        ((dma_req_o & ~flag_o) == '0));

    // R9: interrupt implies some flag is set
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (flag_o != '0));

    // R6: a flag falls only after a clear or a completion pulse
    a_r6_hold_without_clear: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
        (($past(flag_o) & ~flag_o & ~$past(clr_bus_i | clr_pin_i | dma_done_i)) == '0));

    // R3 / R7: an active high level always leaves the flag set
    for (genvar p = 0; p < NPINS; p++) begin : g_lvl
        a_r3_level_high_sets: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(pin_mode_i[p*4 +: 4]) == 4'b1100 && $past(pin_lvl_i[p]))
            |-> flag_o[p]);
    end
endmodule

bind pid_detector pid_checker #(.NPINS(NPINS)) u_pid_checker (
    .clk        (clk),
    .rst        (rst),
    .pin_mode_i (pin_mode_i),
    .pin_lvl_i  (pin_lvl_i),
    .clr_bus_i  (clr_bus_i),
    .clr_pin_i  (clr_pin_i),
    .dma_done_i (dma_done_i),
    .flag_o     (flag_o),
    .irq_o      (irq_o),
    .dma_req_o  (dma_req_o)
);

// File: tb/pid_detector_bench.sv
`timescale 1ns/1ps
module pid_detector_bench;
    localparam int NP = 32;
    localparam int P  = 3;
    localparam int NV = 33;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP*4-1:0]   mode = '0;
    logic [NP-1:0]     lvl = '0, clrb = '0, clrp = '0, done = '0;
    logic [NP-1:0]     flag, dreq;
    logic              irq;
    int checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    pid_detector #(.NPINS(NP)) u_pid_detector (
        .clk(clk), .rst(rst), .pin_mode_i(mode), .pin_lvl_i(lvl),
        .clr_bus_i(clrb), .clr_pin_i(clrp), .dma_done_i(done),
        .flag_o(flag), .irq_o(irq), .dma_req_o(dreq)
    );

    // {mode, lvl, clr_bus, clr_pin, done, exp_flag, exp_irq, exp_dma} for pin P
    localparam logic [10:0] VEC [NV] = '{
        11'b1001_0_000_000, // R2 rise mode, idle
        11'b1001_1_000_110, // R2 rising edge
        11'b1001_1_000_110, // R6 hold
        11'b1001_1_100_000, // R6 bus clear
        11'b1001_0_000_000, // R2 fall ignored
        11'b1010_1_000_000, // R2 rise ignored in fall mode
        11'b1010_0_000_110, // R2 falling edge
        11'b1010_0_010_000, // R6 per-pin clear
        11'b1011_1_000_110, // R2 either edge (rise)
        11'b1011_1_100_000, // R6
        11'b1011_0_000_110, // R2 either edge (fall)
        11'b1011_0_001_110, // R5 done ignored in irq mode
        11'b1011_0_100_000, // R6
        11'b1000_0_000_110, // R3 low level
        11'b1000_0_100_110, // R3 re-assert on clear
        11'b1000_1_100_000, // R3 level gone
        11'b1100_1_000_110, // R3 high level
        11'b1100_0_100_000, // R3
        11'b0001_1_000_101, // R4 dma rise
        11'b0001_1_000_101, // R4 hold
        11'b0001_1_001_000, // R5 done clears
        11'b0010_0_000_101, // R4 dma fall
        11'b0010_0_100_000, // R6 bus clear in dma mode
        11'b0011_1_000_101, // R4 dma either (rise)
        11'b0011_0_001_101, // R7 edge beats done
        11'b0011_0_001_000, // R5
        11'b0000_1_000_000, // R8 disabled
        11'b0000_0_000_000, // R8
        11'b0101_1_000_000, // R8 unlisted code
        11'b1101_0_000_000, // R8 unlisted code
        11'b1001_1_100_110, // R7 edge beats bus clear
        11'b0000_1_000_100, // R9 flag held, outputs gated
        11'b0000_1_100_000  // R6
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at negedge, sample 1 ns after the following posedge (R10)
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: pins high and in rise mode through reset
        for (int i = 0; i < NP; i++) mode[i*4 +: 4] = 4'b1001;
        lvl = '1;
        repeat (3) cyc();
        chk("R1 flags in reset", 64'(flag), 64'h0);
        chk("R1 irq in reset", 64'(irq), 64'h0);
        @(negedge clk); rst = 1'b0;
        cyc(); cyc();
        chk("R1 no false edge after reset", 64'(flag), 64'h0);

        // Vector table on pin P
        @(negedge clk);
        mode = '0; lvl = '0;
        cyc();
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            mode = '0;
            mode[P*4 +: 4] = VEC[v][10:7];
            lvl  = '0; lvl[P]  = VEC[v][6];
            clrb = '0; clrb[P] = VEC[v][5];
            clrp = '0; clrp[P] = VEC[v][4];
            done = '0; done[P] = VEC[v][3];
            cyc();
            chk($sformatf("R10 vec%0d flag", v), 64'(flag[P]), 64'(VEC[v][2]));
            chk($sformatf("R9 vec%0d irq", v), 64'(irq), 64'(VEC[v][1]));
            chk($sformatf("R4 vec%0d dma", v), 64'(dreq[P]), 64'(VEC[v][0]));
        end

        // R6: bus mask clears only selected bits; R9 OR of many
        @(negedge clk);
        clrb = '0; clrp = '0; done = '0; lvl = '0;
        for (int i = 0; i < NP; i++) mode[i*4 +: 4] = 4'b1001;
        cyc();
        @(negedge clk); lvl = '1; cyc();
        chk("R2 all pins rise", 64'(flag), 64'hFFFF_FFFF);
        @(negedge clk); clrb = 32'h0000_FFFF; cyc();
        chk("R6 partial bus clear", 64'(flag), 64'hFFFF_0000);
        chk("R9 irq from remaining", 64'(irq), 64'h1);
        @(negedge clk); clrb = '0; clrp = 32'hFFFF_0000; cyc();
        chk("R6 per-pin clear", 64'(flag), 64'h0);
        chk("R9 irq low", 64'(irq), 64'h0);

        // R4/R5: per-pin request lines and completion
        @(negedge clk); clrp = '0; lvl = '0;
        for (int i = 0; i < NP; i++) mode[i*4 +: 4] = 4'b0001;
        cyc();
        @(negedge clk); lvl = '1; cyc();
        chk("R4 all requests", 64'(dreq), 64'hFFFF_FFFF);
        chk("R9 no irq in dma mode", 64'(irq), 64'h0);
        @(negedge clk); done = 32'hF0F0_F0F0; cyc();
        chk("R5 done selected", 64'(dreq), 64'h0F0F_0F0F);

        // R1: reset clears set flags
        @(negedge clk); done = '0; rst = 1'b1; cyc();
        chk("R1 reset clears", 64'(flag), 64'h0);
        @(negedge clk); rst = 1'b0; cyc();
        chk("R1 no edge after release", 64'(flag), 64'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule